// File: doc/BRIEF.md
# Selectively Tagged Direct-Mapped Data Cache

This block is a direct-mapped data cache for a processor with virtual memory. Each line is tagged in one of two ways. Lines that hold private data carry the upper virtual address bits as their tag, so lookups for them need no translation result. Lines that hold shared data carry a physical tag, so that two tasks reaching one buffer through different virtual addresses land on the same line. A mode flag stored beside each tag records which kind of tag the line holds.

Every access brings a virtual address and a 2-bit class label. A shared access also brings the translated physical tag and the translated superset bits. The superset bits are the index bits that lie above the page offset. For a shared access they are replaced by their physical values before the array is indexed. The low index bits always come straight from the virtual address.

A load miss fetches the whole line through a simple request/response memory port. Stores are write-through with no write-allocate. A flush input invalidates every line, as is needed on a context switch, because virtual tags belong to the running task.

Top module: `sttag_dcache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and mem_req_valid are 0, and every line is invalid, so the first load to any address misses.
- R2: Class 00 is private. Such an access indexes with vaddr[13:5] and compares vaddr[31:14] against a line whose mode is virtual, and req_ptag and req_pss have no effect on its outcome. Two addresses with the same vaddr[13:5] and different vaddr[31:14] evict each other.
- R3: Any class other than 00 is shared. Such an access indexes with {req_pss, vaddr[11:5]} and compares req_ptag against a line whose mode is physical. Two virtual aliases with equal req_ptag, equal req_pss and equal vaddr[11:0] therefore hit the same line, even when their vaddr[31:12] differ.
- R4: A hit requires the stored mode to equal the class of the access (virtual for private, physical for shared), even when the tag bits and the index agree.
- R5: A load miss issues exactly one single-cycle memory read at line address {tag, index, 5'b0}. The tag and index are the ones used for the comparison. The returned 256-bit line holds word k in bits [32k+31:32k]. The load answers with resp_hit=0 and word vaddr[4:2] of that line, and the line is filled with the mode of its class.
- R6: A load hit answers with resp_hit=1 and the stored word, and issues no memory request.
- R7: Every store issues exactly one single-cycle memory write of req_wdata at word address {tag, index, vaddr[4:2], 2'b00}. On a hit it also updates the cached word. A miss allocates no line. The store answers after the memory acknowledges, with resp_hit set to the lookup result and resp_rdata=0.
- R8: A flush pulse while the cache is idle invalidates all lines in that cycle. req_ready is 0 during that cycle, so a request offered together with the flush is taken only afterwards and sees an empty cache.
- R9: Only one request is outstanding at a time. req_ready is 1 only while idle, and each accepted request yields exactly one single-cycle resp_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Cache idle and able to take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual byte address (word aligned) |
| req_class | input | 2 | 00 private, any other value shared |
| req_ptag | input | 18 | Translated physical tag (shared only) |
| req_pss | input | 2 | Translated superset bits (shared only) |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Lookup hit |
| resp_rdata | output | 32 | Load data, 0 for stores |
| mem_req_valid | output | 1 | Memory request pulse |
| mem_req_write | output | 1 | 1 = word write, 0 = line read |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_resp_valid | input | 1 | Memory response or write acknowledge |
| mem_resp_data | input | 256 | Returned line |

## Verification
The bench builds the cache with its default values: 32-bit addresses, 4 KiB pages, 32-byte lines and 16 KiB of storage. This leaves two superset bits, so virtual aliases whose superset bits differ from the physical ones can be tested. It also makes the private and shared index paths diverge, and it lets a private address be built whose tag and index equal those of a physical-mode line, which tests the mode check. The memory model returns address-dependent data, so a wrong superset substitution or a wrong fill address shows up as wrong load data as well as a wrong request address.

// File: rtl/sttag_dcache.sv
module sttag_dcache #(
  parameter int ADDR_W  = 32,
  parameter int PAGE_W  = 12,
  parameter int LINE_W  = 5,
  parameter int CACHE_W = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_vaddr,
  input  logic [1:0]                 req_class,
  input  logic [ADDR_W-CACHE_W-1:0]  req_ptag,
  input  logic [CACHE_W-PAGE_W-1:0]  req_pss,
  input  logic [31:0]                req_wdata,
  output logic                       resp_valid,
  output logic                       resp_hit,
  output logic [31:0]                resp_rdata,
  output logic                       mem_req_valid,
  output logic                       mem_req_write,
  output logic [ADDR_W-1:0]          mem_req_addr,
  output logic [31:0]                mem_req_wdata,
  input  logic                       mem_resp_valid,
  input  logic [(1<<LINE_W)*8-1:0]   mem_resp_data
);
  localparam int IDX_W  = CACHE_W - LINE_W;
  localparam int SS_W   = CACHE_W - PAGE_W;
  localparam int TAG_W  = ADDR_W - CACHE_W;
  localparam int WSEL_W = LINE_W - 2;
  localparam int LBITS  = (1 << LINE_W) * 8;
  localparam int NLINES = 1 << IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FILL, S_STORE} st_t;
  st_t st;

  logic [NLINES-1:0] vld;
  logic [NLINES-1:0] mode_q;
  logic [TAG_W-1:0]  tag_q [NLINES];
  logic [LBITS-1:0]  dat_q [NLINES];

  logic              r_write, r_shared, r_hit;
  logic [TAG_W-1:0]  r_tag;
  logic [IDX_W-1:0]  r_idx;
  logic [WSEL_W-1:0] r_word;
  logic [31:0]       r_wdata;

  wire             in_shared = |req_class;
  wire [IDX_W-1:0] in_idx = in_shared ? {req_pss, req_vaddr[PAGE_W-1:LINE_W]}
                                      : req_vaddr[CACHE_W-1:LINE_W];
  wire [TAG_W-1:0] in_tag = in_shared ? req_ptag : req_vaddr[ADDR_W-1:CACHE_W];

  wire        hit = vld[r_idx] && (mode_q[r_idx] == r_shared) && (tag_q[r_idx] == r_tag);
  wire [31:0] cur_word = dat_q[r_idx][{r_word, 5'b0} +: 32];

  assign req_ready = (st == S_IDLE) && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      vld           <= '0;
      resp_valid    <= 1'b0;
      resp_hit      <= 1'b0;
      resp_rdata    <= '0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      r_write       <= 1'b0;
      r_shared      <= 1'b0;
      r_hit         <= 1'b0;
      r_tag         <= '0;
      r_idx         <= '0;
      r_word        <= '0;
      r_wdata       <= '0;
    end else begin
      resp_valid    <= 1'b0;
      mem_req_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (flush) begin
            vld <= '0;
          end else if (req_valid) begin
            r_write  <= req_write;
            r_shared <= in_shared;
            r_tag    <= in_tag;
            r_idx    <= in_idx;
            r_word   <= req_vaddr[LINE_W-1:2];
            r_wdata  <= req_wdata;
            st       <= S_LOOK;
          end
        end
        S_LOOK: begin
          r_hit         <= hit;
          mem_req_write <= r_write;
          mem_req_wdata <= r_wdata;
          mem_req_addr  <= r_write ? {r_tag, r_idx, r_word, 2'b00}
                                   : {r_tag, r_idx, {LINE_W{1'b0}}};
          if (!r_write && hit) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_rdata <= cur_word;
            st         <= S_IDLE;
          end else begin
            mem_req_valid <= 1'b1;
            st            <= r_write ? S_STORE : S_FILL;
          end
        end
        S_FILL: begin
          if (mem_resp_valid) begin
            vld[r_idx] <= 1'b1;
            resp_valid <= 1'b1;
            resp_hit   <= 1'b0;
            resp_rdata <= mem_resp_data[{r_word, 5'b0} +: 32];
            st         <= S_IDLE;
          end
        end
        default: begin
          if (mem_resp_valid) begin
            resp_valid <= 1'b1;
            resp_hit   <= r_hit;
            resp_rdata <= '0;
            st         <= S_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && mem_resp_valid) begin
      tag_q[r_idx]  <= r_tag;
      mode_q[r_idx] <= r_shared;
      dat_q[r_idx]  <= mem_resp_data;
    end else if (st == S_LOOK && r_write && hit) begin
      dat_q[r_idx][{r_word, 5'b0} +: 32] <= r_wdata;
    end
  end
endmodule

module sttag_dcache_chk (
  input logic clk,
  input logic rst_n,
  input logic flush,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic resp_valid,
  input logic resp_hit,
  input logic mem_req_valid,
  input logic mem_req_write
);
  logic busy, wr_q, mem_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wr_q     <= 1'b0;
      mem_seen <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        busy     <= 1'b1;
        wr_q     <= req_write;
        mem_seen <= 1'b0;
      end else begin
        if (resp_valid) busy <= 1'b0;
        if (mem_req_valid) mem_seen <= 1'b1;
      end
    end
  end

  a_r9_resp_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> busy);
  a_r9_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!busy || resp_valid));
  a_r5_mem_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  a_r5_mem_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (busy && !mem_seen));
  a_r7_mem_kind: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_write == wr_q));
  a_r7_store_went_out: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && wr_q) |-> mem_seen);
  a_r6_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit && !wr_q) |-> !mem_seen);
  a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !busy) |=> (!resp_valid && !mem_req_valid));
endmodule

bind sttag_dcache sttag_dcache_chk chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .resp_valid(resp_valid),
  .resp_hit(resp_hit), .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write)
);

// File: tb/sttag_dcache_tb_top.sv
`timescale 1ns/1ps
module sttag_dcache_tb_top;
  localparam int NL = 512;

  logic         clk = 1'b0, rst_n = 1'b0, flush = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]  req_vaddr = '0, req_wdata = '0;
  logic [1:0]   req_class = '0, req_pss = '0;
  logic [17:0]  req_ptag = '0;
  logic         req_ready, resp_valid, resp_hit, mem_req_valid, mem_req_write;
  logic [31:0]  resp_rdata, mem_req_addr, mem_req_wdata;
  logic         mem_resp_valid = 1'b0;
  logic [255:0] mem_resp_data = '0;

  sttag_dcache dut_i (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;

  typedef struct { logic hit; logic [31:0] data; string rq; } exp_t;
  typedef struct { logic wr; logic [31:0] addr; logic [31:0] wd; string rq; } mexp_t;
  exp_t  sq[$];
  mexp_t mq[$];

  logic [31:0] wmem [int unsigned];
  bit          rv [NL];
  bit          rm [NL];
  logic [17:0] rt [NL];
  logic [31:0] rd [NL][8];

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mword(logic [31:0] a);
    if (wmem.exists(a)) return wmem[a];
    return a * 32'h9E3779B1 + 32'h01234567;
  endfunction

  always @(negedge clk) begin
    if (resp_valid) begin
      if (sq.size() == 0) chk(0, "R9", "unexpected response", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sq.pop_front();
        chk(resp_hit == e.hit, e.rq, "hit", {31'd0, resp_hit}, {31'd0, e.hit});
        chk(resp_rdata == e.data, e.rq, "rdata", resp_rdata, e.data);
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic        wr;
        logic [31:0] ad, wd;
        logic [255:0] ln;
        wr = mem_req_write; ad = mem_req_addr; wd = mem_req_wdata;
        if (mq.size() == 0) chk(0, "R6", "unexpected memory request", ad, 32'd0);
        else begin
          mexp_t m;
          m = mq.pop_front();
          chk(wr == m.wr, m.rq, "memory request kind", {31'd0, wr}, {31'd0, m.wr});
          chk(ad == m.addr, m.rq, "memory address", ad, m.addr);
          if (m.wr) chk(wd == m.wd, m.rq, "memory wdata", wd, m.wd);
        end
        repeat (2) @(negedge clk);
        if (wr) wmem[ad] = wd;
        for (int k = 0; k < 8; k++) ln[k*32 +: 32] = mword({ad[31:5], 5'b0} + k*4);
        mem_resp_data  = ln;
        mem_resp_valid = 1'b1;
        @(negedge clk);
        mem_resp_valid = 1'b0;
      end
    end
  end

  task automatic access(bit wr, logic [31:0] va, logic [1:0] cls, logic [17:0] pt,
                        logic [1:0] ps, logic [31:0] wd, string rq, bit fl = 0);
    bit sh; logic [8:0] idx; logic [17:0] tg; logic [2:0] w; bit h; exp_t e; mexp_t m;
    if (fl) for (int i = 0; i < NL; i++) rv[i] = 0;
    sh  = (cls != 2'b00);
    idx = sh ? {ps, va[11:5]} : va[13:5];
    tg  = sh ? pt : va[31:14];
    w   = va[4:2];
    h   = rv[idx] && (rm[idx] == sh) && (rt[idx] == tg);
    e.hit = h; e.rq = rq;
    if (wr) begin
      m.wr = 1; m.addr = {tg, idx, w, 2'b00}; m.wd = wd; m.rq = rq; mq.push_back(m);
      if (h) rd[idx][w] = wd;
      e.data = '0;
    end else if (h) begin
      e.data = rd[idx][w];
    end else begin
      m.wr = 0; m.addr = {tg, idx, 5'b0}; m.wd = '0; m.rq = rq; mq.push_back(m);
      for (int k = 0; k < 8; k++) rd[idx][k] = mword({tg, idx, 5'b0} + k*4);
      if (wr == 0 && mq.size() > 1) ;
      rv[idx] = 1; rm[idx] = sh; rt[idx] = tg;
      e.data = rd[idx][w];
    end
    sq.push_back(e);
    @(negedge clk);
    req_write = wr; req_vaddr = va; req_class = cls; req_ptag = pt; req_pss = ps;
    req_wdata = wd; req_valid = 1'b1; flush = fl;
    #1;
    if (fl) begin
      chk(req_ready == 1'b0, "R8", "ready during flush", {31'd0, req_ready}, 32'd0);
      @(negedge clk); flush = 1'b0; #1;
    end
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9", "ready while busy", {31'd0, req_ready}, 32'd0);
    wait (sq.size() == 0);
    @(negedge clk);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1; #1;
    chk(req_ready == 1'b0, "R8", "ready during flush", {31'd0, req_ready}, 32'd0);
    for (int i = 0; i < NL; i++) rv[i] = 0;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) rv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", {31'd0, req_ready}, 32'd1);
    chk(resp_valid == 1'b0, "R1", "resp_valid after reset", {31'd0, resp_valid}, 32'd0);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", {31'd0, mem_req_valid}, 32'd0);

    access(0, 32'h0000_1040, 2'b00, 18'h0, 2'b00, 0, "R1");
    access(0, 32'h0000_1040, 2'b00, 18'h3_1234, 2'b10, 0, "R6");
    access(0, 32'h0000_105C, 2'b00, 18'h0_0F0F, 2'b01, 0, "R2");
    for (int i = 0; i < 4; i++) access(0, 32'h0100_0000 + i*32'h0000_0420, 2'b00, 18'h0, 2'b00, 0, "R5");

    access(0, 32'h0000_0104, 2'b01, 18'h0_002A, 2'b11, 0, "R3");
    access(0, 32'h7FFF_3104, 2'b10, 18'h0_002A, 2'b11, 0, "R3");
    access(0, 32'h1234_5108, 2'b11, 18'h0_002A, 2'b11, 0, "R3");
    access(0, 32'h000A_B104, 2'b00, 18'h0, 2'b00, 0, "R4");
    access(0, 32'h0000_0104, 2'b01, 18'h0_002A, 2'b11, 0, "R4");

    access(1, 32'h0000_1044, 2'b00, 18'h0, 2'b00, 32'hDEAD_BEEF, "R7");
    access(0, 32'h0000_1044, 2'b00, 18'h0, 2'b00, 0, "R7");
    access(1, 32'h5000_2008, 2'b00, 18'h0, 2'b00, 32'h0BAD_F00D, "R7");
    access(0, 32'h5000_2008, 2'b00, 18'h0, 2'b00, 0, "R7");
    access(1, 32'h0000_0F10, 2'b01, 18'h0_0055, 2'b01, 32'h1357_9BDF, "R7");
    access(0, 32'h0000_2F10, 2'b01, 18'h0_0055, 2'b01, 0, "R7");

    access(0, 32'h0000_5040, 2'b00, 18'h0, 2'b00, 0, "R2");
    access(0, 32'h0000_1040, 2'b00, 18'h0, 2'b00, 0, "R2");

    do_flush();
    access(0, 32'h0000_1040, 2'b00, 18'h0, 2'b00, 0, "R8");
    access(0, 32'h0000_1040, 2'b00, 18'h0, 2'b00, 0, "R8", 1);
    access(0, 32'h0000_1040, 2'b00, 18'h0, 2'b00, 0, "R9");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule